// File: doc/BRIEF.md
# Cache-Invalidate System Instruction Trap Decoder

This block examines one system-instruction word together with the processor's privilege context. It decides what happens to a request to invalidate every instruction cache across the inner-shareable domain. There are three possible outcomes. The instruction can be refused as undefined. It can be diverted to the hypervisor level (level 2) with a fixed syndrome class. Or it can be forwarded to the cache controller as an invalidate request. A word whose encoding is not this operation is flagged as foreign, so that another decoder can claim it.

The decision is registered. An instruction offered with `in_valid_i` while `in_ready_o` is high produces its outcome one cycle later. The undefined, trap and foreign outcomes last one cycle. The invalidate request is held until the cache side accepts it, and the decoder takes no new instruction while that request is outstanding.

The destination-register field of the instruction carries no data. A static configuration input selects how a value other than all-ones in that field is treated.

Top module: `sid_trap_dec`

## Requirements
- R1: The operation is recognised only for op0=2'b01, op1=3'b000, crn=4'b0111, crm=4'b0001, op2=3'b000. Any other accepted encoding pulses `not_mine_o` for one cycle and raises no other outcome.
- R2: A recognised instruction accepted at level 0 (`cur_lvl_i`=0) pulses `undef_o` and issues no invalidate.
- R3: At level 1, with `lvl2_en_i`=1 and `trap_pou_i`=1, the result is a trap: `trap_o` pulses and `trap_class_o` reads 6'h18 in the same cycle.
- R4: At level 1, with `lvl2_en_i`=1 and `trap_icall_i`=1, the result is a trap with class 6'h18, whatever `trap_pou_i` is.
- R5: At level 1, with `lvl2_en_i`=1 and `fgt_trap_i`=1, the result is a trap with class 6'h18 only when `lvl3_impl_i`=0 or `fgt_en_i`=1. With `lvl3_impl_i`=1 and `fgt_en_i`=0, the fine-grained bit has no effect.
- R6: With no trap condition at level 1, and always at levels 2 and 3, a recognised instruction raises `inv_valid_o`. All trap controls are ignored whenever `lvl2_en_i`=0.
- R7: When `rt_i` is not 5'b11111 and `xt_undef_i`=1, a recognised instruction gives `undef_o` at every level. When `xt_undef_i`=0, it behaves exactly as if `rt_i` were 5'b11111.
- R8: At most one of `undef_o`, `trap_o`, `inv_valid_o`, `not_mine_o` is high in any cycle. Each accepted instruction raises exactly one of them.
- R9: `inv_valid_o` stays high until a cycle with `inv_ready_i`=1 and then drops. `in_ready_o` is low while it is high, and instructions offered then are ignored.
- R10: The outcome appears in the cycle after the accepting clock edge. `undef_o`, `trap_o` and `not_mine_o` last one cycle, and `trap_class_o` is zero when `trap_o` is low.
- R11: Synchronous active-high `rst` clears all outcome outputs, including a pending invalidate, and leaves `in_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction offered this cycle |
| in_ready_o | output | 1 | Decoder can take an instruction |
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| rt_i | input | 5 | Destination-register field |
| cur_lvl_i | input | 2 | Current privilege level, 0 to 3 |
| lvl2_en_i | input | 1 | Hypervisor level enabled |
| lvl3_impl_i | input | 1 | Top level implemented |
| trap_pou_i | input | 1 | Hypervisor control: trap unification-point maintenance |
| trap_icall_i | input | 1 | Hypervisor control: trap invalidate-all cache maintenance |
| fgt_trap_i | input | 1 | Fine-grained trap bit for this operation |
| fgt_en_i | input | 1 | Top-level enable for fine-grained traps |
| xt_undef_i | input | 1 | Static: 1 = non-all-ones rt is undefined, 0 = treat as all-ones |
| undef_o | output | 1 | Undefined-instruction outcome pulse |
| trap_o | output | 1 | Trap-to-level-2 outcome pulse |
| trap_class_o | output | 6 | Syndrome class, valid with trap_o |
| inv_valid_o | output | 1 | Invalidate request to cache controller |
| inv_ready_i | input | 1 | Cache controller accepts the request |
| not_mine_o | output | 1 | Encoding is not this operation |

## Verification
The priority chain at level 1 is the hardest part to reach from the ports. Several trap controls must be set together, with the hypervisor level enabled, and the fine-grained bit must be disarmed with the top level implemented but its enable clear. Uniform random stimulus seldom makes those combinations, so directed cases set each control pair in turn and also check that the same settings are ignored at level 0, at levels 2 and 3, and with the hypervisor level disabled. The random phase weights the encoding toward a match and the privilege level toward 1, and it holds back `inv_ready_i` for random stretches while offering instructions that must be ignored.

// File: rtl/sid_pkg.sv
package sid_pkg;
   typedef enum logic [1:0] {
      DEC_FOREIGN = 2'd0,
      DEC_UNDEF   = 2'd1,
      DEC_TRAP    = 2'd2,
      DEC_INV     = 2'd3
   } dec_kind_e;
endpackage

// File: rtl/sid_match.sv
module sid_match #(
   parameter int OP0_W = 2,
   parameter int OP1_W = 3,
   parameter int CRN_W = 4,
   parameter int CRM_W = 4,
   parameter int OP2_W = 3,
   parameter int RT_W  = 5,
   parameter logic [OP0_W-1:0] OP0_VAL = 2'b01,
   parameter logic [OP1_W-1:0] OP1_VAL = 3'b000,
   parameter logic [CRN_W-1:0] CRN_VAL = 4'b0111,
   parameter logic [CRM_W-1:0] CRM_VAL = 4'b0001,
   parameter logic [OP2_W-1:0] OP2_VAL = 3'b000
) (
   input  logic [OP0_W-1:0] op0,
   input  logic [OP1_W-1:0] op1,
   input  logic [CRN_W-1:0] crn,
   input  logic [CRM_W-1:0] crm,
   input  logic [OP2_W-1:0] op2,
   input  logic [RT_W-1:0]  rt,
   output logic             hit,
   output logic             rt_zero_reg
);
   localparam int                NFIELD  = 5;
   localparam logic [RT_W-1:0]   RT_NONE = {RT_W{1'b1}};

   logic [NFIELD-1:0] field_eq;

   always_comb begin
      field_eq[0] = (op0 == OP0_VAL);
      field_eq[1] = (op1 == OP1_VAL);
      field_eq[2] = (crn == CRN_VAL);
      field_eq[3] = (crm == CRM_VAL);
      field_eq[4] = (op2 == OP2_VAL);
   end

   assign hit         = &field_eq;
   assign rt_zero_reg = (rt == RT_NONE);
endmodule

// File: rtl/sid_policy.sv
module sid_policy
   import sid_pkg::*;
#(
   parameter int LVL_W           = 2,
   parameter bit XT_RUNTIME      = 1'b1,
   parameter bit XT_STRICT_FIXED = 1'b1
) (
   input  logic             hit,
   input  logic             rt_zero_reg,
   input  logic             xt_strict_cfg,
   input  logic [LVL_W-1:0] lvl,
   input  logic             lvl2_en,
   input  logic             lvl3_impl,
   input  logic             trap_pou,
   input  logic             trap_icall,
   input  logic             fgt_trap,
   input  logic             fgt_en,
   output dec_kind_e        kind
);
   localparam logic [LVL_W-1:0] LVL_USER = '0;
   localparam logic [LVL_W-1:0] LVL_KERN = LVL_W'(1);

   logic xt_strict;
   logic xt_reject;
   logic fgt_armed;
   logic kern_trap;

   generate
      if (XT_RUNTIME) begin : g_xt_cfg
         assign xt_strict = xt_strict_cfg;
      end else begin : g_xt_fix
         assign xt_strict = XT_STRICT_FIXED;
      end
   endgenerate

   assign xt_reject = xt_strict & ~rt_zero_reg;
   assign fgt_armed = fgt_trap & (~lvl3_impl | fgt_en);
   // Priority order: unification-point trap, then invalidate-all trap,
   // then the fine-grained bit; all three need level 2 enabled.
   assign kern_trap = lvl2_en & (trap_pou | trap_icall | fgt_armed);

   always_comb begin
      if (!hit) begin
         kind = DEC_FOREIGN;
      end else if (xt_reject) begin
         kind = DEC_UNDEF;
      end else if (lvl == LVL_USER) begin
         kind = DEC_UNDEF;
      end else if (lvl == LVL_KERN) begin
         kind = kern_trap ? DEC_TRAP : DEC_INV;
      end else begin
         kind = DEC_INV;
      end
   end
endmodule

// File: rtl/sid_out_reg.sv
module sid_out_reg
   import sid_pkg::*;
#(
   parameter int                 CLASS_W    = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               accept,
   input  dec_kind_e          kind,
   input  logic               inv_ready,
   output logic               undef_q,
   output logic               trap_q,
   output logic [CLASS_W-1:0] class_q,
   output logic               inv_q,
   output logic               foreign_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         undef_q   <= 1'b0;
         trap_q    <= 1'b0;
         class_q   <= '0;
         inv_q     <= 1'b0;
         foreign_q <= 1'b0;
      end else begin
         undef_q   <= 1'b0;
         trap_q    <= 1'b0;
         class_q   <= '0;
         foreign_q <= 1'b0;
         if (inv_q && inv_ready) begin
            inv_q <= 1'b0;
         end
         if (accept) begin
            unique case (kind)
               DEC_FOREIGN: foreign_q <= 1'b1;
               DEC_UNDEF:   undef_q   <= 1'b1;
               DEC_TRAP: begin
                  trap_q  <= 1'b1;
                  class_q <= TRAP_CLASS;
               end
               DEC_INV:     inv_q     <= 1'b1;
               default:     foreign_q <= 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/sid_trap_dec.sv
module sid_trap_dec
   import sid_pkg::*;
#(
   parameter int                 OP0_W           = 2,
   parameter int                 OP1_W           = 3,
   parameter int                 CRN_W           = 4,
   parameter int                 CRM_W           = 4,
   parameter int                 OP2_W           = 3,
   parameter int                 RT_W            = 5,
   parameter int                 LVL_W           = 2,
   parameter int                 CLASS_W         = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS      = 6'h18,
   parameter bit                 XT_RUNTIME      = 1'b1,
   parameter bit                 XT_STRICT_FIXED = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid_i,
   output logic               in_ready_o,
   input  logic [OP0_W-1:0]   op0_i,
   input  logic [OP1_W-1:0]   op1_i,
   input  logic [CRN_W-1:0]   crn_i,
   input  logic [CRM_W-1:0]   crm_i,
   input  logic [OP2_W-1:0]   op2_i,
   input  logic [RT_W-1:0]    rt_i,
   input  logic [LVL_W-1:0]   cur_lvl_i,
   input  logic               lvl2_en_i,
   input  logic               lvl3_impl_i,
   input  logic               trap_pou_i,
   input  logic               trap_icall_i,
   input  logic               fgt_trap_i,
   input  logic               fgt_en_i,
   input  logic               xt_undef_i,
   output logic               undef_o,
   output logic               trap_o,
   output logic [CLASS_W-1:0] trap_class_o,
   output logic               inv_valid_o,
   input  logic               inv_ready_i,
   output logic               not_mine_o
);
   generate
      if (LVL_W < 2) begin : g_bad_lvl
         $error("LVL_W must hold levels 0 to 3");
      end
      if (CLASS_W < 1 || RT_W < 1) begin : g_bad_w
         $error("field widths must be positive");
      end
      if (OP0_W < 2 || OP1_W < 1 || CRN_W < 3 || CRM_W < 1 || OP2_W < 1) begin : g_bad_enc
         $error("encoding fields too narrow for the match values");
      end
   endgenerate

   logic      hit;
   logic      rt_zero_reg;
   logic      accept;
   dec_kind_e kind;

   assign in_ready_o = ~inv_valid_o;
   assign accept     = in_valid_i & in_ready_o;

   sid_match #(
      .OP0_W(OP0_W), .OP1_W(OP1_W), .CRN_W(CRN_W),
      .CRM_W(CRM_W), .OP2_W(OP2_W), .RT_W(RT_W),
      .OP0_VAL(OP0_W'(2'b01)), .OP1_VAL(OP1_W'(0)),
      .CRN_VAL(CRN_W'(4'b0111)), .CRM_VAL(CRM_W'(1)),
      .OP2_VAL(OP2_W'(0))
   ) u_match (
      .op0(op0_i), .op1(op1_i), .crn(crn_i), .crm(crm_i), .op2(op2_i),
      .rt(rt_i), .hit(hit), .rt_zero_reg(rt_zero_reg)
   );

   sid_policy #(
      .LVL_W(LVL_W), .XT_RUNTIME(XT_RUNTIME), .XT_STRICT_FIXED(XT_STRICT_FIXED)
   ) u_policy (
      .hit(hit), .rt_zero_reg(rt_zero_reg), .xt_strict_cfg(xt_undef_i),
      .lvl(cur_lvl_i), .lvl2_en(lvl2_en_i), .lvl3_impl(lvl3_impl_i),
      .trap_pou(trap_pou_i), .trap_icall(trap_icall_i),
      .fgt_trap(fgt_trap_i), .fgt_en(fgt_en_i), .kind(kind)
   );

   sid_out_reg #(
      .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)
   ) u_out (
      .clk(clk), .rst(rst), .accept(accept), .kind(kind),
      .inv_ready(inv_ready_i), .undef_q(undef_o), .trap_q(trap_o),
      .class_q(trap_class_o), .inv_q(inv_valid_o), .foreign_q(not_mine_o)
   );
endmodule

// File: rtl/sid_trap_dec_chk.sv
module sid_trap_dec_chk #(
   parameter int                 LVL_W      = 2,
   parameter int                 RT_W       = 5,
   parameter int                 CLASS_W    = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid_i,
   input logic               in_ready_o,
   input logic [1:0]         op0_i,
   input logic [2:0]         op1_i,
   input logic [3:0]         crn_i,
   input logic [3:0]         crm_i,
   input logic [2:0]         op2_i,
   input logic [RT_W-1:0]    rt_i,
   input logic [LVL_W-1:0]   cur_lvl_i,
   input logic               undef_o,
   input logic               trap_o,
   input logic [CLASS_W-1:0] trap_class_o,
   input logic               inv_valid_o,
   input logic               inv_ready_i,
   input logic               not_mine_o
);
   logic take;
   logic enc_ok;
   assign take   = in_valid_i & in_ready_o;
   assign enc_ok = (op0_i == 2'b01) && (op1_i == 3'b000) && (crn_i == 4'b0111)
                   && (crm_i == 4'b0001) && (op2_i == 3'b000);

   AST_FOREIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
      take && !enc_ok |=> not_mine_o);                                      // R1
   AST_USER_NO_INV: assert property (@(posedge clk) disable iff (rst)
      take && enc_ok && cur_lvl_i == '0 |=> undef_o && !inv_valid_o);       // R2
   AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
      trap_o |-> trap_class_o == TRAP_CLASS);                               // R3
   AST_HIGH_LVL_INV: assert property (@(posedge clk) disable iff (rst)
      take && enc_ok && cur_lvl_i[1] && rt_i == {RT_W{1'b1}} |=> inv_valid_o); // R6
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
      $onehot0({undef_o, trap_o, inv_valid_o, not_mine_o}));                // R8
   AST_INV_HOLD: assert property (@(posedge clk) disable iff (rst)
      inv_valid_o && !inv_ready_i |=> inv_valid_o);                         // R9
   AST_INV_DROP: assert property (@(posedge clk) disable iff (rst)
      inv_valid_o && inv_ready_i |=> !inv_valid_o);                         // R9
   AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
      inv_valid_o |-> !in_ready_o);                                         // R9
   AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
      !take |=> !undef_o && !trap_o && !not_mine_o);                        // R10
   AST_CLASS_IDLE: assert property (@(posedge clk) disable iff (rst)
      !trap_o |-> trap_class_o == '0);                                      // R10
endmodule

bind sid_trap_dec sid_trap_dec_chk #(
   .LVL_W(LVL_W), .RT_W(RT_W), .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)
) u_chk (
   .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
   .op0_i(op0_i), .op1_i(op1_i), .crn_i(crn_i), .crm_i(crm_i), .op2_i(op2_i),
   .rt_i(rt_i), .cur_lvl_i(cur_lvl_i), .undef_o(undef_o), .trap_o(trap_o),
   .trap_class_o(trap_class_o), .inv_valid_o(inv_valid_o),
   .inv_ready_i(inv_ready_i), .not_mine_o(not_mine_o)
);

// File: tb/sid_trap_dec_tb.sv
module sid_trap_dec_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid_i = 1'b0;
   logic       in_ready_o;
   logic [1:0] op0_i = '0;
   logic [2:0] op1_i = '0;
   logic [3:0] crn_i = '0;
   logic [3:0] crm_i = '0;
   logic [2:0] op2_i = '0;
   logic [4:0] rt_i = '1;
   logic [1:0] cur_lvl_i = '0;
   logic       lvl2_en_i = 1'b0, lvl3_impl_i = 1'b0;
   logic       trap_pou_i = 1'b0, trap_icall_i = 1'b0;
   logic       fgt_trap_i = 1'b0, fgt_en_i = 1'b0;
   logic       xt_undef_i = 1'b0;
   logic       undef_o, trap_o, inv_valid_o, not_mine_o;
   logic [5:0] trap_class_o;
   logic       inv_ready_i = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int seed  = 32'h5eed_1c0d;

   always #10 clk = ~clk;   // 50 MHz

   sid_trap_dec u_dut (.*);

   typedef struct {
      logic [1:0] op0; logic [2:0] op1; logic [3:0] crn; logic [3:0] crm;
      logic [2:0] op2; logic [4:0] rt;  logic [1:0] lvl;
      logic l2, l3, pou, icall, fgt, fen, xtu;
   } stim_t;

   // 0 foreign, 1 undefined, 2 trap, 3 invalidate
   function automatic int expect_kind(stim_t s);
      if (!(s.op0 == 2'b01 && s.op1 == 3'b000 && s.crn == 4'b0111 &&
            s.crm == 4'b0001 && s.op2 == 3'b000)) return 0;
      if (s.rt != 5'b11111 && s.xtu) return 1;
      if (s.lvl == 2'd0) return 1;
      if (s.lvl == 2'd1) begin
         if (s.l2 && s.pou) return 2;
         if (s.l2 && s.icall) return 2;
         if (s.l2 && s.fgt && (!s.l3 || s.fen)) return 2;
      end
      return 3;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic stim_t base_hit();
      stim_t s;
      s.op0 = 2'b01; s.op1 = 3'b000; s.crn = 4'b0111; s.crm = 4'b0001;
      s.op2 = 3'b000; s.rt = 5'b11111; s.lvl = 2'd1;
      s.l2 = 1'b0; s.l3 = 1'b0; s.pou = 1'b0; s.icall = 1'b0;
      s.fgt = 1'b0; s.fen = 1'b0; s.xtu = 1'b0;
      return s;
   endfunction

   task automatic drive(stim_t s);
      op0_i = s.op0; op1_i = s.op1; crn_i = s.crn; crm_i = s.crm; op2_i = s.op2;
      rt_i = s.rt; cur_lvl_i = s.lvl; lvl2_en_i = s.l2; lvl3_impl_i = s.l3;
      trap_pou_i = s.pou; trap_icall_i = s.icall; fgt_trap_i = s.fgt;
      fgt_en_i = s.fen; xt_undef_i = s.xtu;
   endtask

   // Offer one instruction at a falling edge, sample the outcome one edge later.
   task automatic run_one(stim_t s, string req, int hold);
      int ek;
      int got;
      ek = expect_kind(s);
      @(negedge clk);
      drive(s);
      in_valid_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0;
      got = {undef_o, trap_o, inv_valid_o, not_mine_o};
      case (ek)
         0: check(got == 4'b0001, req, got, 4'b0001);
         1: check(got == 4'b1000, req, got, 4'b1000);
         2: check(got == 4'b0100 && trap_class_o == 6'h18, req,
                  {got, 2'b00, trap_class_o}, {4'b0100, 8'h18});
         default: check(got == 4'b0010 && !in_ready_o, req, got, 4'b0010);
      endcase
      if (ek == 3) begin
         for (int k = 0; k < hold; k++) begin
            stim_t z;
            z = base_hit();
            z.lvl = 2'd0;
            drive(z);
            in_valid_i = 1'b1;                 // must be ignored while busy
            @(negedge clk);
            check(inv_valid_o && !undef_o && !in_ready_o, "R9 hold/ignore",
                  {inv_valid_o, undef_o, in_ready_o}, 3'b100);
         end
         in_valid_i  = 1'b0;
         inv_ready_i = 1'b1;
         @(negedge clk);
         inv_ready_i = 1'b0;
         check(!inv_valid_o && in_ready_o, "R9 release",
               {inv_valid_o, in_ready_o}, 2'b01);
      end else begin
         @(negedge clk);
         check({undef_o, trap_o, not_mine_o, trap_class_o} == '0, "R10 pulse",
               {undef_o, trap_o, not_mine_o, trap_class_o}, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      stim_t s;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check({undef_o, trap_o, inv_valid_o, not_mine_o, trap_class_o} == '0 && in_ready_o,
            "R11 reset", {undef_o, trap_o, inv_valid_o, not_mine_o}, 0);
      rst = 1'b0;

      // R1: each field off by one bit
      s = base_hit(); s.op0 = 2'b11; run_one(s, "R1 op0", 0);
      s = base_hit(); s.crn = 4'b0110; run_one(s, "R1 crn", 0);
      s = base_hit(); s.crm = 4'b0000; s.lvl = 2'd3; run_one(s, "R1 crm", 0);
      s = base_hit(); s.op2 = 3'b001; run_one(s, "R1 op2", 0);
      s = base_hit(); s.op1 = 3'b100; run_one(s, "R1 op1", 0);
      // R2
      s = base_hit(); s.lvl = 2'd0; run_one(s, "R2 user", 0);
      // R3 / R4 / R5 priority cases
      s = base_hit(); s.l2 = 1; s.pou = 1; run_one(s, "R3 pou", 0);
      s = base_hit(); s.l2 = 1; s.icall = 1; run_one(s, "R4 icall", 0);
      s = base_hit(); s.l2 = 1; s.pou = 1; s.icall = 1; run_one(s, "R4 both", 0);
      s = base_hit(); s.l2 = 1; s.fgt = 1; s.l3 = 0; run_one(s, "R5 no top", 0);
      s = base_hit(); s.l2 = 1; s.fgt = 1; s.l3 = 1; s.fen = 1; run_one(s, "R5 enabled", 0);
      s = base_hit(); s.l2 = 1; s.fgt = 1; s.l3 = 1; s.fen = 0; run_one(s, "R5 gated", 2);
      // R6
      s = base_hit(); s.pou = 1; s.icall = 1; s.fgt = 1; run_one(s, "R6 l2 off", 1);
      s = base_hit(); s.lvl = 2'd2; s.l2 = 1; s.pou = 1; s.icall = 1; run_one(s, "R6 lvl2", 0);
      s = base_hit(); s.lvl = 2'd3; s.l2 = 1; s.fgt = 1; run_one(s, "R6 lvl3", 3);
      // R7
      s = base_hit(); s.rt = 5'd3; s.xtu = 1; s.lvl = 2'd3; run_one(s, "R7 strict", 0);
      s = base_hit(); s.rt = 5'd3; s.xtu = 0; s.lvl = 2'd3; run_one(s, "R7 lenient", 0);
      s = base_hit(); s.rt = 5'd0; s.xtu = 0; s.l2 = 1; s.icall = 1; run_one(s, "R7 lenient trap", 0);

      // R8: random mix, each accept must give exactly the modelled outcome
      for (int i = 0; i < 400; i++) begin
         s = base_hit();
         if ($urandom_range(0, 4) == 0) begin
            s.op0 = 2'($urandom); s.op1 = 3'($urandom); s.crn = 4'($urandom);
            s.crm = 4'($urandom); s.op2 = 3'($urandom);
         end
         s.rt  = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'b11111;
         s.lvl = ($urandom_range(0, 1) == 0) ? 2'd1 : 2'($urandom);
         s.l2 = 1'($urandom); s.l3 = 1'($urandom); s.pou = ($urandom_range(0, 3) == 0);
         s.icall = ($urandom_range(0, 3) == 0); s.fgt = 1'($urandom);
         s.fen = 1'($urandom); s.xtu = 1'($urandom);
         run_one(s, "R8 random", $urandom_range(0, 3));
      end

      // R11: reset while an invalidate is pending
      s = base_hit(); s.lvl = 2'd2;
      @(negedge clk); drive(s); in_valid_i = 1'b1;
      @(negedge clk); in_valid_i = 1'b0;
      check(inv_valid_o, "R11 pending", inv_valid_o, 1);
      rst = 1'b1;
      @(negedge clk);
      check(!inv_valid_o && in_ready_o, "R11 clear", {inv_valid_o, in_ready_o}, 2'b01);
      rst = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule